// File: doc/BRIEF.md
# Boot-Time Serial EEPROM Configuration Loader

This block runs once after reset. It acts as the only master on a two-wire serial bus. It fetches a fixed-length block of bytes from an external serial EEPROM and streams each byte into an on-chip configuration register file. Byte k read from the EEPROM is written to register k. There is no host in the loop: the block starts on its own, works through one fixed bus sequence, and then parks the bus in the released state permanently.

The sequence has two parts. In the first part the block sends the device address with the write direction, then a word address of zero. In the second part it issues a repeated start, sends the device address with the read direction, and reads the bytes back to back. The block acknowledges every byte except the final one, then issues a stop. The SCL output is driven directly. SDA is open-drain: an enable pulls the line low, and the pad level is read back. One bit period is cut into four quarter phases, each a fixed number of system clocks long. That number is derived from the clock frequency and the target bit rate, which defaults to 50 kbit/s. If the slave fails to acknowledge any address byte, the load is abandoned with a stop and an error flag.

Top module: `cfgld_eeprom_boot`

## Requirements
- R1: While reset is high, and at all times after the load has finished, SCL is high and the SDA pull-down enable is low.
- R2: Let Q = CLK_HZ/(4*BIT_HZ) system clock cycles. Every SCL high pulse that ends lasts exactly 2*Q cycles.
- R3: Each transaction opens with SDA falling while SCL is high. A successful load contains exactly two such events: the first START and the repeated START.
- R4: While the block sends or receives bits, SDA changes only while SCL is low. Every SDA change seen during an SCL high phase is a START or a STOP.
- R5: The first transaction sends the byte {DEV_ADDR, 0}, then the word-address byte 0x00. Both are sent most significant bit first.
- R6: After the repeated START, the block sends the byte {DEV_ADDR, 1}.
- R7: Each read byte is assembled most significant bit first. It produces exactly one single-cycle pulse on reg_we_o, carrying reg_addr_o = k and reg_data_o = the byte. The index k runs from 0 to NBYTES-1 in order.
- R8: In the acknowledge slot after each read byte, the block pulls SDA low (ACK = 0). The exception is the last byte, where SDA stays released (NACK = 1).
- R9: If SDA is high in the acknowledge slot after any of the three address bytes, the block sends no further byte. It issues a STOP, raises err_o, and produces no register write.
- R10: done_o stays low until the single STOP has been seen on the bus. It then rises and stays high. On a successful load, err_o stays low.
- R11: A STOP is SDA rising while SCL is high. After it, SCL does not fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the load starts when it is released |
| scl_o | output | 1 | Serial clock level |
| sda_oe_o | output | 1 | High pulls the serial data line low |
| sda_i | input | 1 | Sampled level of the serial data line |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_addr_o | output | ADDR_W | Register address for the write |
| reg_data_o | output | 8 | Register data for the write |
| done_o | output | 1 | Load sequence finished (sticky) |
| err_o | output | 1 | An address byte was not acknowledged (sticky) |

## Verification
Two events land on the same clock. The register-write strobe for a read byte fires on the cycle that opens that byte's acknowledge slot. For the final byte, that same cycle also opens the NACK that ends the read. The bench provokes this by reading the full block under several data patterns. A behavioural slave records each acknowledge level the master drives, and the bench judges the collision by checking three things: the write count equals NBYTES, the last write carries the last address and byte, and the recorded acknowledge list ends in a single 1.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    // Sequencer phase of the bus engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_TX,
        PH_RSTART,
        PH_RX,
        PH_STOP
    } phase_e;

    // Which outbound byte the transmitter is currently shifting
    typedef enum logic [1:0] {
        TB_DEVW,
        TB_WORD,
        TB_DEVR
    } txsel_e;

    // Requested line levels (1 = released/high)
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_t;

    localparam logic [7:0] WORD_ADDR = 8'h00;

    // System clocks per quarter bit, never below one
    function automatic int unsigned qtr_cycles(int unsigned clk_hz, int unsigned bit_hz);
        int unsigned r;
        r = clk_hz / (bit_hz * 4);
        return (r < 1) ? 1 : r;
    endfunction

    // Line levels per quarter for framing phases; bit phases get the clock shape
    function automatic bus_t frame_levels(phase_e ph, logic [1:0] q);
        bus_t b;
        b.scl = q[0] ^ q[1];
        b.sda = 1'b1;
        case (ph)
            PH_START, PH_RSTART: b.sda = ~q[1];
            PH_STOP: begin
                b.scl = (q != 2'd0);
                b.sda = q[1];
            end
            PH_IDLE: begin
                b.scl = 1'b1;
                b.sda = 1'b1;
            end
            default: ;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cfgld_qtick.sv
module cfgld_qtick #(
    parameter int unsigned QTR = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned QW = (QTR > 1) ? $clog2(QTR) : 1;
    localparam logic [QW-1:0] TOP = QW'(QTR - 1);

    logic [QW-1:0] cnt;

    assign tick_o = (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst || tick_o) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    // R2: the quarter counter never runs past its terminal value
    assert_qtr_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);

endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h50,
    parameter int unsigned NBYTES   = 16,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_o,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [7:0]        reg_data_o,
    output logic              done_o,
    output logic              err_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NBYTES - 1);

    phase_e            st;
    txsel_e            sel;
    logic [1:0]        q;
    logic [3:0]        bitn;
    logic [7:0]        shreg;
    logic [ADDR_W-1:0] cnt;
    logic              nack_q, fin, err, we;
    logic [ADDR_W-1:0] waddr;
    logic [7:0]        wdata;
    bus_t              lv;
    logic              last_byte;

    assign last_byte = (cnt == LAST);

    always_comb begin
        lv = frame_levels(st, q);
        if (st == PH_TX)      lv.sda = (bitn == 4'd8) ? 1'b1 : shreg[7];
        else if (st == PH_RX) lv.sda = (bitn == 4'd8) ? last_byte : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PH_IDLE;
            sel    <= TB_DEVW;
            q      <= '0;
            bitn   <= '0;
            shreg  <= '0;
            cnt    <= '0;
            nack_q <= 1'b0;
            fin    <= 1'b0;
            err    <= 1'b0;
            we     <= 1'b0;
            waddr  <= '0;
            wdata  <= '0;
        end else begin
            we <= 1'b0;
            if (tick) begin
                if (st != PH_IDLE) q <= q + 2'd1;
                case (st)
                    PH_IDLE: if (!fin) st <= PH_START;
                    PH_START, PH_RSTART: if (q == 2'd3) begin
                        bitn  <= '0;
                        shreg <= {DEV_ADDR, (st == PH_RSTART)};
                        sel   <= (st == PH_RSTART) ? TB_DEVR : TB_DEVW;
                        st    <= PH_TX;
                    end
                    PH_TX: begin
                        if (q == 2'd1 && bitn == 4'd8) nack_q <= sda_i;
                        if (q == 2'd3) begin
                            if (bitn != 4'd8) begin
                                shreg <= {shreg[6:0], 1'b0};
                                bitn  <= bitn + 4'd1;
                            end else if (nack_q) begin
                                err <= 1'b1;
                                st  <= PH_STOP;
                            end else begin
                                case (sel)
                                    TB_DEVW: begin
                                        sel   <= TB_WORD;
                                        shreg <= WORD_ADDR;
                                        bitn  <= '0;
                                    end
                                    TB_WORD: st <= PH_RSTART;
                                    default: begin
                                        st   <= PH_RX;
                                        bitn <= '0;
                                        cnt  <= '0;
                                    end
                                endcase
                            end
                        end
                    end
                    PH_RX: begin
                        if (q == 2'd1 && bitn != 4'd8) shreg <= {shreg[6:0], sda_i};
                        if (q == 2'd3) begin
                            if (bitn == 4'd7) begin
                                we    <= 1'b1;
                                waddr <= cnt;
                                wdata <= shreg;
                            end
                            if (bitn != 4'd8)   bitn <= bitn + 4'd1;
                            else if (last_byte) st   <= PH_STOP;
                            else begin
                                cnt  <= cnt + 1'b1;
                                bitn <= '0;
                            end
                        end
                    end
                    PH_STOP: if (q == 2'd3) begin
                        st  <= PH_IDLE;
                        fin <= 1'b1;
                    end
                    default: st <= PH_IDLE;
                endcase
            end
        end
    end

    assign scl_o      = lv.scl;
    assign sda_o      = lv.sda;
    assign reg_we_o   = we;
    assign reg_addr_o = waddr;
    assign reg_data_o = wdata;
    assign done_o     = fin;
    assign err_o      = err;

    // R10: completion is entered only out of the stop phase
    assert_done_after_stop_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(fin) |-> $past(st) == PH_STOP);

    // R7: write strobes come only from the receive phase, within the block
    assert_we_from_read_R7: assert property (@(posedge clk) disable iff (rst)
        we |-> ($past(st) == PH_RX) && (waddr <= LAST));

    // R4: data level holds across an SCL high phase inside a bit
    assert_sda_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (lv.scl && $past(lv.scl) && (st == PH_TX || st == PH_RX) && $past(st) == st)
        |-> lv.sda == $past(lv.sda));

    // R11: once finished the bus stays released for good
    assert_idle_forever_R11: assert property (@(posedge clk) disable iff (rst)
        fin |=> fin && lv.scl && lv.sda);

    // R9: an abandoned load writes nothing
    assert_no_write_on_err_R9: assert property (@(posedge clk) disable iff (rst)
        err |-> !we);

endmodule

// File: rtl/cfgld_eeprom_boot.sv
module cfgld_eeprom_boot
    import cfgld_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 200_000_000,
    parameter int unsigned BIT_HZ   = 50_000,
    parameter logic [6:0]  DEV_ADDR = 7'h50,
    parameter int unsigned NBYTES   = 16,
    parameter int unsigned ADDR_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic              scl_o,
    output logic              sda_oe_o,
    input  logic              sda_i,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [7:0]        reg_data_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int unsigned QTR = qtr_cycles(CLK_HZ, BIT_HZ);

    logic tick;
    logic sda_lvl;

    cfgld_qtick #(.QTR(QTR)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    cfgld_seq #(
        .DEV_ADDR (DEV_ADDR),
        .NBYTES   (NBYTES),
        .ADDR_W   (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .sda_i      (sda_i),
        .scl_o      (scl_o),
        .sda_o      (sda_lvl),
        .reg_we_o   (reg_we_o),
        .reg_addr_o (reg_addr_o),
        .reg_data_o (reg_data_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    assign sda_oe_o = ~sda_lvl;

endmodule

// File: tb/cfgld_eeprom_boot_tb_top.sv
module cfgld_eeprom_boot_tb_top;
    localparam int N      = 8;
    localparam int CLK_HZ = 200_000_000;
    localparam int BIT_HZ = 12_500_000;
    localparam int Q      = CLK_HZ / (4 * BIT_HZ);
    localparam int AW     = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          scl, sda_oe, we, done, err;
    logic [AW-1:0] waddr;
    logic [7:0]    wdata;
    logic          slave_pull = 1'b0;
    wire           sda_line = ~(sda_oe | slave_pull);

    cfgld_eeprom_boot #(
        .CLK_HZ (CLK_HZ), .BIT_HZ (BIT_HZ), .DEV_ADDR (7'h50), .NBYTES (N)
    ) dut_i (
        .clk (clk), .rst (rst), .scl_o (scl), .sda_oe_o (sda_oe), .sda_i (sda_line),
        .reg_we_o (we), .reg_addr_o (waddr), .reg_data_o (wdata),
        .done_o (done), .err_o (err)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0] mem [256];
    int nack_at;

    // behavioural slave and bus monitor state
    logic prev_scl, prev_sda;
    int   bitcnt, tr_byte, gbyte, ptr, n_start, n_stop, hi_run;
    bit   rd, stop_seen, sending, acked, first_fall, late_fall;
    logic [7:0] rxsh;
    logic [7:0] sent_q[$];
    logic       mack_q[$];
    logic [7:0] wd_q[$];
    int         wa_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            prev_scl = scl;
            prev_sda = sda_line;
            hi_run   = 0;
        end else begin
            // per-clock comparisons
            chk(!(done && !stop_seen), "R10 done before stop", int'(done), 0);
            if (we) begin
                chk(rd && tr_byte > 0, "R7 strobe outside read data", 1, 0);
                wa_q.push_back(int'(waddr));
                wd_q.push_back(wdata);
            end
            if (prev_scl && !scl) begin
                if (first_fall) chk(hi_run == 2 * Q, "R2 scl high width", hi_run, 2 * Q);
                first_fall = 1'b1;
                if (stop_seen) late_fall = 1'b1;
            end
            hi_run = scl ? hi_run + 1 : 0;
            // framing events
            if (prev_scl && scl && prev_sda && !sda_line) begin
                n_start++;
                bitcnt  = 0;
                tr_byte = 0;
                rd      = 1'b0;
                sending = 1'b0;
            end
            if (prev_scl && scl && !prev_sda && sda_line) begin
                n_stop++;
                stop_seen = 1'b1;
            end
            // rising edge: sample
            if (!prev_scl && scl && n_start > 0 && !stop_seen) begin
                if (bitcnt < 8) begin
                    if (!rd || tr_byte == 0) rxsh = {rxsh[6:0], sda_line};
                end else if (bitcnt == 8 && rd && tr_byte > 0) begin
                    mack_q.push_back(sda_line);
                end
                bitcnt++;
            end
            // falling edge: drive
            if (prev_scl && !scl && n_start > 0 && !stop_seen) begin
                if (bitcnt == 8) begin
                    if (!rd || tr_byte == 0) begin
                        sent_q.push_back(rxsh);
                        if (tr_byte == 0) rd = rxsh[0];
                        else if (gbyte == 1) ptr = int'(rxsh);
                        acked      = (gbyte != nack_at);
                        slave_pull = acked;
                        gbyte++;
                    end else begin
                        slave_pull = 1'b0;
                        ptr        = (ptr + 1) & 255;
                    end
                end else if (bitcnt == 9) begin
                    bitcnt = 0;
                    tr_byte++;
                    if (rd && ((tr_byte == 1 && acked) ||
                               (tr_byte > 1 && mack_q.size() > 0 && mack_q[$] == 1'b0))) begin
                        sending    = 1'b1;
                        slave_pull = ~mem[ptr][7];
                    end else begin
                        sending    = 1'b0;
                        slave_pull = 1'b0;
                    end
                end else if (bitcnt >= 1 && bitcnt <= 7 && rd && tr_byte > 0 && sending) begin
                    slave_pull = ~mem[ptr][7 - bitcnt];
                end
            end
            prev_scl = scl;
            prev_sda = sda_line;
        end
    end

    task automatic run_case(input int nk, input int seed);
        bit fin_ok;
        logic [7:0] exp_sent [3];
        int nsent;
        exp_sent[0] = 8'hA0;
        exp_sent[1] = 8'h00;
        exp_sent[2] = 8'hA1;
        @(negedge clk);
        rst = 1'b1;
        nack_at = nk;
        for (int i = 0; i < 256; i++) mem[i] = 8'((seed * 37 + i * 29) ^ (i << 3));
        bitcnt = 0; tr_byte = 0; gbyte = 0; ptr = 0; n_start = 0; n_stop = 0;
        rd = 0; stop_seen = 0; sending = 0; acked = 0; first_fall = 0; late_fall = 0;
        rxsh = '0; slave_pull = 1'b0;
        sent_q.delete(); mack_q.delete(); wd_q.delete(); wa_q.delete();
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(scl && !sda_oe && !we && !done && !err, "R1 reset state",
            int'({scl, sda_oe, we, done, err}), 5'b10000);
        #1 rst = 1'b0;
        fin_ok = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (done) begin
                fin_ok = 1'b1;
                break;
            end
        end
        chk(fin_ok, "R10 watchdog load completion", int'(fin_ok), 1);
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (!(scl && !sda_oe && done)) begin
                chk(1'b0, "R1 bus released after completion", int'({scl, sda_oe, done}), 3'b101);
                break;
            end
        end
        chk(!late_fall, "R11 scl fell after stop", int'(late_fall), 0);
        chk(n_stop == 1, "R11 stop count", n_stop, 1);
        chk(err == (nk >= 0), "R10 R9 error flag", int'(err), int'(nk >= 0));
        chk(n_start == ((nk == 0 || nk == 1) ? 1 : 2), "R3 start count", n_start,
            (nk == 0 || nk == 1) ? 1 : 2);
        nsent = (nk >= 0) ? nk + 1 : 3;
        chk(sent_q.size() == nsent, "R9 R6 bytes sent", sent_q.size(), nsent);
        for (int i = 0; i < sent_q.size() && i < 3; i++) begin
            if (i == 2) chk(sent_q[i] == exp_sent[i], "R6 read address byte", int'(sent_q[i]), int'(exp_sent[i]));
            else        chk(sent_q[i] == exp_sent[i], "R5 write address or word byte", int'(sent_q[i]), int'(exp_sent[i]));
        end
        if (nk >= 0) begin
            chk(wd_q.size() == 0, "R9 no register writes", wd_q.size(), 0);
        end else begin
            chk(wd_q.size() == N, "R7 write count", wd_q.size(), N);
            for (int i = 0; i < wd_q.size(); i++) begin
                chk(wa_q[i] == i, "R7 write address", wa_q[i], i);
                chk(wd_q[i] == mem[i], "R7 write data", int'(wd_q[i]), int'(mem[i]));
            end
            chk(mack_q.size() == N, "R8 ack slot count", mack_q.size(), N);
            for (int i = 0; i < mack_q.size(); i++)
                chk(mack_q[i] == (i == N - 1), "R8 master ack level", int'(mack_q[i]), int'(i == N - 1));
        end
        // R4: the only SDA edges under SCL high were starts and stops (counted above)
        chk(n_start + n_stop <= 3, "R4 framing edges", n_start + n_stop, 3);
    endtask

    initial begin
        run_case(-1, 1);
        run_case(-1, 5);
        run_case(0, 2);
        run_case(1, 3);
        run_case(2, 4);
        run_case(-1, 9);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule